// File: doc/BRIEF.md
# Flash Bulk-Erase Command Decoder

This block is the device-side command interface of a small parallel flash. It follows the asynchronous chip-enable, write-strobe and output-enable pins, synchronises them to an internal clock and decodes the byte written on each bus write. Only the command sequence that erases the whole array and then checks it byte by byte is decoded. A lone erase code only arms the device. Erasing begins when a second erase code follows directly, and only if the programming supply is reported good. It ends when a verify command arrives.

A small register file stands in for the cell array. Its reset contents follow a fixed pattern. While erase is active, every byte advances one step toward all-ones on each clock, and all bytes move together. In verify mode a read returns the byte at the latched verify address, not the byte at the bus address. Host software steps through the addresses. It re-erases when a byte does not read FFh and resumes at the failed address.

Top module: `erase_cmd_ctrl`

## Requirements
- R1: After reset the decoder is in read mode, with erase_active, margin_mode and verify_addr all 0. The byte at array index i is ((17*i) mod 256) XOR 33h.
- R2: A single write of 20h arms the device without erasing. erase_active stays 0 and the array keeps its contents.
- R3: A write of 20h that directly follows an armed state starts the erase if prog_supply_ok is high. erase_active rises after the write strobe returns high.
- R4: Without prog_supply_ok the array never changes. A second 20h written while the supply is low returns the decoder to read mode without erasing. If the supply drops during an erase, erase_active drops and the array holds.
- R5: Once started, the erase continues through writes of any code other than A0h.
- R6: A write of A0h ends any erase and enters verify mode (margin_mode=1). verify_addr takes the bus address present when the later of the two falling edges (write strobe, chip enable) is seen.
- R7: Erase acts on all bytes in parallel. On each active clock every byte b becomes b OR (b shifted left by one with a 1 shifted in), so any byte reaches FFh after at most 8 active cycles.
- R8: With chip enable and output enable both low, rd_data returns the array byte at bus_addr in read mode and the byte at verify_addr in verify mode. Otherwise rd_data is 00h.
- R9: If any byte other than 20h follows the arming write, the arming is cancelled and no erase takes place. A following A0h enters verify mode directly.
- R10: Writing 00h, 40h or FFh leaves verify mode for read mode. Any undefined code (for example 55h) leaves the mode unchanged.
- R11: From verify mode, a new 20h-20h sequence restarts the erase. Verification can then resume at the address that failed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en_n | input | 1 | Chip enable, active low, asynchronous |
| wr_en_n | input | 1 | Write strobe, active low, asynchronous |
| out_en_n | input | 1 | Output enable, active low |
| bus_addr | input | AW | Byte address |
| bus_din | input | 8 | Command byte written by the host |
| prog_supply_ok | input | 1 | High when the programming supply is valid |
| rd_data | output | 8 | Read data |
| erase_active | output | 1 | Erase in progress on the array |
| verify_addr | output | AW | Latched verify address |
| margin_mode | output | 1 | Verify (margin read) mode |

## Verification
The hardest state to reach is a partially erased array. In that state some bytes already read FFh and others do not. It is the only way to exercise a failed verify followed by a re-erase. The bench reaches it by back-to-back writes: the second erase code is followed, with the minimum gap, by a one-cycle verify strobe, so only a few erase steps run. That is enough to finish bytes with many ones but not the all-zero byte. The address-latch rule is checked by staggering the two falling edges, with the bus address changed between them, in both orders.

// File: rtl/erase_cmd_pkg.sv
package erase_cmd_pkg;

  typedef enum logic [1:0] {
    ST_READ   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_ERASE  = 2'd2,
    ST_VERIFY = 2'd3
  } cmd_state_t;

  localparam logic [7:0] OP_ERASE  = 8'h20;
  localparam logic [7:0] OP_VERIFY = 8'hA0;
  localparam logic [7:0] OP_READ   = 8'h00;
  localparam logic [7:0] OP_PROG   = 8'h40;
  localparam logic [7:0] OP_RESET  = 8'hFF;

  // Reset contents of array index idx
  function automatic logic [7:0] seed_byte(input int unsigned idx);
    logic [7:0] t;
    t = 8'(idx * 17);
    return t ^ 8'h33;
  endfunction

  // One erase step: set the lowest cleared bits from the bottom upward
  function automatic logic [7:0] erase_step(input logic [7:0] b);
    return b | {b[6:0], 1'b1};
  endfunction

  // Codes that take the decoder back to read mode
  function automatic logic is_exit_cmd(input logic [7:0] c);
    return (c == OP_READ) || (c == OP_PROG) || (c == OP_RESET);
  endfunction

endpackage

// File: rtl/bus_edge_sync.sv
module bus_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en_n,
  input  logic wr_en_n,
  output logic wr_start,
  output logic wr_end
);
  logic [STAGES-1:0] ce_sh;
  logic [STAGES-1:0] we_sh;
  logic              act_q;
  logic              act;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ce_sh <= '1;
          we_sh <= '1;
        end else begin
          ce_sh <= chip_en_n;
          we_sh <= wr_en_n;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ce_sh <= '1;
          we_sh <= '1;
        end else begin
          ce_sh <= {ce_sh[STAGES-2:0], chip_en_n};
          we_sh <= {we_sh[STAGES-2:0], wr_en_n};
        end
      end
    end
  endgenerate

  // A write is in progress while both synchronised lines are low
  assign act = ~ce_sh[STAGES-1] & ~we_sh[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end

  assign wr_start = act & ~act_q;   // later falling edge
  assign wr_end   = ~act & act_q;   // first rising edge

endmodule

// File: rtl/cmd_fsm.sv
module cmd_fsm
  import erase_cmd_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_start,
  input  logic          wr_end,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_din,
  input  logic          prog_supply_ok,
  output cmd_state_t    state,
  output logic [AW-1:0] verify_addr,
  output logic          erase_active,
  output logic          margin_mode
);
  cmd_state_t    nxt;
  logic [AW-1:0] addr_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        addr_cap <= '0;
    else if (wr_start) addr_cap <= bus_addr;
  end

  always_comb begin
    nxt = state;
    if (wr_end) begin
      unique case (state)
        ST_READ, ST_VERIFY: begin
          if (bus_din == OP_ERASE)       nxt = ST_SETUP;
          else if (bus_din == OP_VERIFY) nxt = ST_VERIFY;
          else if (is_exit_cmd(bus_din)) nxt = ST_READ;
        end
        ST_SETUP: begin
          if (bus_din == OP_ERASE)       nxt = prog_supply_ok ? ST_ERASE : ST_READ;
          else if (bus_din == OP_VERIFY) nxt = ST_VERIFY;
          else                           nxt = ST_READ;
        end
        ST_ERASE: begin
          if (bus_din == OP_VERIFY)      nxt = ST_VERIFY;
        end
        default: nxt = ST_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_READ;
      verify_addr <= '0;
    end else begin
      state <= nxt;
      if (wr_end && bus_din == OP_VERIFY && nxt == ST_VERIFY)
        verify_addr <= addr_cap;
    end
  end

  assign erase_active = (state == ST_ERASE) && prog_supply_ok;
  assign margin_mode  = (state == ST_VERIFY);

  // R3: erase is entered only straight from the armed state
  a_r3_two_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERASE && $past(state) != ST_ERASE) |-> ($past(state) == ST_SETUP && $past(prog_supply_ok)));

  // R5: writes other than the verify code keep the erase running
  a_r5_erase_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ERASE && wr_end && bus_din != OP_VERIFY) |=> state == ST_ERASE);

  // R6: verify address changes only at the end of a write
  a_r6_addr_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(verify_addr) |-> ($past(wr_end) && state == ST_VERIFY));

endmodule

// File: rtl/cell_array.sv
module cell_array
  import erase_cmd_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          erase_en,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_byte
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH*8-1:0] mem_flat;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        mem_flat[i*8 +: 8] <= seed_byte(i);
        else if (erase_en) mem_flat[i*8 +: 8] <= erase_step(mem_flat[i*8 +: 8]);
      end
    end
  endgenerate

  assign rd_byte = mem_flat[rd_addr*8 +: 8];

  // R4: the array is frozen unless erase is enabled
  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !erase_en |=> $stable(mem_flat));

  // R7: erasing only ever sets bits
  a_r7_bits_only_set: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> (($past(mem_flat) & ~mem_flat) == '0));

endmodule

// File: rtl/erase_cmd_ctrl.sv
module erase_cmd_ctrl
  import erase_cmd_pkg::*;
#(
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chip_en_n,
  input  logic          wr_en_n,
  input  logic          out_en_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_din,
  input  logic          prog_supply_ok,
  output logic [7:0]    rd_data,
  output logic          erase_active,
  output logic [AW-1:0] verify_addr,
  output logic          margin_mode
);
  logic          wr_start;
  logic          wr_end;
  cmd_state_t    state;
  logic [AW-1:0] rd_addr;
  logic [7:0]    rd_byte;

  bus_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .wr_en_n(wr_en_n),
    .wr_start(wr_start), .wr_end(wr_end)
  );

  cmd_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_end(wr_end),
    .bus_addr(bus_addr), .bus_din(bus_din), .prog_supply_ok(prog_supply_ok),
    .state(state), .verify_addr(verify_addr), .erase_active(erase_active),
    .margin_mode(margin_mode)
  );

  assign rd_addr = margin_mode ? verify_addr : bus_addr;

  cell_array #(.AW(AW)) u_array (
    .clk(clk), .rst_n(rst_n), .erase_en(erase_active),
    .rd_addr(rd_addr), .rd_byte(rd_byte)
  );

  assign rd_data = (!chip_en_n && !out_en_n) ? rd_byte : 8'h00;

  // R4: no erase without a valid programming supply
  a_r4_supply_gate: assert property (@(posedge clk) disable iff (!rst_n)
    erase_active |-> prog_supply_ok);

endmodule

// File: tb/erase_cmd_ctrl_test.sv
module erase_cmd_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          chip_en_n = 1'b1;
  logic          wr_en_n = 1'b1;
  logic          out_en_n = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_din = 8'h00;
  logic          prog_supply_ok = 1'b1;
  logic [7:0]    rd_data;
  logic          erase_active;
  logic [AW-1:0] verify_addr;
  logic          margin_mode;

  int checks = 0;
  int errors = 0;

  erase_cmd_ctrl #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .wr_en_n(wr_en_n),
    .out_en_n(out_en_n), .bus_addr(bus_addr), .bus_din(bus_din),
    .prog_supply_ok(prog_supply_ok), .rd_data(rd_data),
    .erase_active(erase_active), .verify_addr(verify_addr), .margin_mode(margin_mode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] pattern(input int i);
    int s;
    s = ((i << 4) + i) % 256;
    return 8'(s) ^ 8'b0011_0011;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; chip_en_n = 1'b1; wr_en_n = 1'b1; out_en_n = 1'b1; prog_supply_ok = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d, input int low_cyc, input int tail_cyc);
    @(negedge clk);
    bus_addr = a; bus_din = d; chip_en_n = 1'b0; wr_en_n = 1'b0;
    repeat (low_cyc) @(negedge clk);
    wr_en_n = 1'b1; chip_en_n = 1'b1;
    repeat (tail_cyc) @(negedge clk);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; chip_en_n = 1'b0; out_en_n = 1'b0;
    #1 d = rd_data;
    @(negedge clk);
    chip_en_n = 1'b1; out_en_n = 1'b1;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    do_reset();
    check("R1 erase_active", erase_active, 0);
    check("R1 margin_mode", margin_mode, 0);
    check("R1 verify_addr", verify_addr, 0);
    for (int i = 0; i < N; i++) begin
      bus_read(AW'(i), d);
      check("R1/R8 seed byte", d, pattern(i));
    end
    @(negedge clk); bus_addr = 4'd3; chip_en_n = 1'b0; out_en_n = 1'b1;
    #1 check("R8 idle output", rd_data, 8'h00);
    chip_en_n = 1'b1;
  endtask

  task automatic t_single_setup();
    logic [7:0] d;
    do_reset();
    bus_write(0, 8'h20, 4, 4);
    repeat (10) @(negedge clk);
    check("R2 no erase", erase_active, 0);
    bus_read(4'd3, d);
    check("R2 array kept", d, 8'h00);
    // R9: cancel with undefined code, then another 20h arms only
    bus_write(0, 8'h55, 4, 4);
    bus_write(0, 8'h20, 4, 4);
    check("R9 cancel no erase", erase_active, 0);
    bus_write(0, 8'hFF, 4, 4);
    bus_write(0, 8'h20, 4, 4);
    bus_write(4'd7, 8'hA0, 4, 4);
    check("R9 setup then verify", margin_mode, 1);
    check("R9 verify addr", verify_addr, 7);
    bus_read(0, d);
    check("R9 array untouched", d, pattern(7));
  endtask

  task automatic t_supply();
    logic [7:0] d0;
    logic [7:0] d1;
    do_reset();
    prog_supply_ok = 1'b0;
    bus_write(0, 8'h20, 4, 4);
    bus_write(0, 8'h20, 4, 4);
    repeat (10) @(negedge clk);
    check("R4 no erase without supply", erase_active, 0);
    bus_read(4'd3, d0);
    check("R4 array kept", d0, 8'h00);
    prog_supply_ok = 1'b1;
    bus_write(0, 8'h20, 4, 4);
    check("R4 back to read, armed only", erase_active, 0);
    bus_write(0, 8'h20, 4, 4);
    check("R3 erase started", erase_active, 1);
    prog_supply_ok = 1'b0;
    repeat (2) @(negedge clk);
    check("R4 supply drop stops erase", erase_active, 0);
    bus_read(4'd3, d0);
    repeat (5) @(negedge clk);
    bus_read(4'd3, d1);
    check("R4 array holds", d1, d0);
    prog_supply_ok = 1'b1;
    bus_write(0, 8'h40, 4, 4);
    check("R5 erase continues", erase_active, 1);
    bus_write(0, 8'h20, 4, 4);
    check("R5 erase continues 20h", erase_active, 1);
    bus_write(4'd3, 8'hA0, 4, 4);
    check("R6 erase ended", erase_active, 0);
    check("R6 margin mode", margin_mode, 1);
  endtask

  task automatic t_partial_and_reerase();
    logic [7:0] d;
    do_reset();
    bus_write(0, 8'h20, 4, 3);
    bus_write(0, 8'h20, 4, 3);
    bus_write(4'd3, 8'hA0, 1, 4);
    check("R6 verify entered", margin_mode, 1);
    bus_read(0, d);
    check("R7 zero byte not yet erased", (d == 8'hFF), 0);
    bus_write(4'd0, 8'hA0, 4, 4);
    bus_read(4'd9, d);
    check("R7 byte 0 erased in parallel", d, 8'hFF);
    // R11: re-erase from verify and resume at failed address
    bus_write(0, 8'h20, 4, 4);
    bus_write(0, 8'h20, 4, 20);
    bus_write(4'd3, 8'hA0, 4, 4);
    bus_read(0, d);
    check("R11 resumed byte erased", d, 8'hFF);
    for (int i = 0; i < N; i++) begin
      bus_write(AW'(i), 8'hA0, 4, 4);
      bus_read(0, d);
      check("R7 all erased", d, 8'hFF);
    end
  endtask

  task automatic t_addr_latch_exit();
    logic [7:0] d;
    do_reset();
    // write strobe first, chip enable later: address at CE fall wins
    @(negedge clk);
    bus_addr = 4'd5; bus_din = 8'hA0; wr_en_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_addr = 4'd9; chip_en_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_en_n = 1'b1; chip_en_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 later edge CE", verify_addr, 9);
    bus_read(0, d);
    check("R8 margin read", d, pattern(9));
    // chip enable first, write strobe later
    @(negedge clk);
    bus_addr = 4'd2; chip_en_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_addr = 4'd6; wr_en_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_en_n = 1'b1; chip_en_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 later edge WE", verify_addr, 6);
    bus_write(0, 8'h55, 4, 4);
    check("R10 undefined ignored", margin_mode, 1);
    bus_write(0, 8'h40, 4, 4);
    check("R10 program setup exits", margin_mode, 0);
    bus_read(4'd4, d);
    check("R8 normal read", d, pattern(4));
    bus_write(4'd1, 8'hA0, 4, 4);
    bus_write(0, 8'hFF, 4, 4);
    check("R10 reset code exits", margin_mode, 0);
    bus_write(4'd1, 8'hA0, 4, 4);
    bus_write(0, 8'h00, 4, 4);
    check("R10 read code exits", margin_mode, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset_state();
    t_single_setup();
    t_supply();
    t_partial_and_reerase();
    t_addr_latch_exit();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule